// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a free-running nanosecond time of day for precision time protocol hardware. Every clock tick adds a fixed 8 ns nominal step. A 32-bit sub-nanosecond residue sits below the nanosecond count. A signed fractional addend goes into that residue on every tick, and its carries and borrows nudge the nanosecond count. This lets software trim the clock frequency without stepping the time. Timestamp capture logic reads the live value straight from the output ports.

Software reaches the counter through a small register interface of 32-bit words. Three words make up the time:

- the sub-ns residue,
- the low 32 nanosecond bits,
- the upper 8 nanosecond bits.

Reading the residue freezes a coherent copy of the whole value, so later reads of the other two words cannot tear across a carry. The time is loaded by staging the low word and then writing the high word. The counter starts halted after reset, and clearing bit 31 of the control word starts it.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the nanosecond count, the sub-ns residue and the adjust word are zero. The control word reads 0x8000_0000, meaning the counter is halted.
- R2: While control bit 31 is 1, the time holds its value on every tick. Only bit 31 of the control word is stored; its other bits read as zero.
- R3: When the counter runs with a zero adjust magnitude, the nanosecond count rises by exactly 8 per tick and the residue does not change.
- R4: The adjust word uses bit 31 as a sign (1 = subtract) and bits 30:0 as a magnitude in units of 2^-32 ns. On each running tick the 72-bit value {ns, residue} changes by 8·2^32 plus the magnitude, or 8·2^32 minus the magnitude, modulo 2^72.
- R5: The 40-bit nanosecond count wraps modulo 2^40.
- R6: Register addresses are: 0 = sub-ns residue, 1 = ns[31:0], 2 = ns[39:32] in bits 7:0 (bits 31:8 read zero), 3 = adjust word, 4 = control word. Read data is registered and appears after the clock edge that samples the read strobe. Any other address reads zero.
- R7: A read of address 0 captures the full time at that edge. Later reads of addresses 1 and 2 return the captured copy until address 2 is read. A fresh read of address 0 captures again.
- R8: When no captured copy is held, reads of addresses 1 and 2 return the live time at the sampling edge.
- R9: A write to address 0 stages a residue and a write to address 1 stages a low nanosecond word. A write to address 2 loads ns = {wdata[7:0], staged low} and residue = staged residue, both taken as zero if they were not staged since the last load. That tick does not step, and both staged words clear.
- R10: The adjust word reads back as all 32 bits last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per nominal 8 ns step |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| time_ns | output | 40 | Live nanosecond count |
| time_frac | output | 32 | Live sub-ns residue |

## Verification
The counter is swept over a set of adjust words and the live outputs are compared on every tick against a 72-bit arithmetic model. The set covers zero, a small and the largest positive magnitude, a small and the largest negative magnitude, and negative zero. This separates carry handling from borrow handling and shows that the sign bit is not treated as part of the magnitude. A load just below 2^40 exposes the wrap. Read sequences are also run, with reads spaced apart while the counter runs:
- capture, then read low and high;
- low and high reads with no capture held;
- a double capture.

A design that reads live values in place of the held copy fails these read sequences, as does one that fails to re-capture.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    parameter int NS_W    = 40;
    parameter int FRAC_W  = 32;
    parameter int WORD_W  = 32;
    parameter int ADDR_W  = 3;
    parameter int STEP_NS = 8;
    localparam int HI_W   = NS_W - WORD_W;
    localparam int MAG_W  = WORD_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        A_SUBNS = 3'd0,
        A_NSLO  = 3'd1,
        A_NSHI  = 3'd2,
        A_ADJ   = 3'd3,
        A_CTRL  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } adj_t;
endpackage

// File: rtl/ptp_tod_step.sv
module ptp_tod_step
    import ptp_tod_pkg::*;
(
    input  tod_t cur,
    input  adj_t adj,
    output tod_t nxt
);
    logic [FRAC_W:0] fsum;
    logic            carry;
    logic            borrow;

    always_comb begin
        if (adj.neg) begin
            fsum = {1'b0, cur.frac} - {1'b0, 1'b0, adj.mag};
        end else begin
            fsum = {1'b0, cur.frac} + {1'b0, 1'b0, adj.mag};
        end
        carry    = fsum[FRAC_W] & ~adj.neg;
        borrow   = fsum[FRAC_W] &  adj.neg;
        nxt.frac = fsum[FRAC_W-1:0];
        nxt.ns   = cur.ns + NS_W'(STEP_NS) + NS_W'(carry) - NS_W'(borrow);
    end
endmodule

// File: rtl/ptp_tod_wstage.sv
module ptp_tod_wstage
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              load,
    output tod_t              load_val
);
    logic [WORD_W-1:0] stage_lo;
    logic [FRAC_W-1:0] stage_frac;

    assign load          = wr && (addr == A_NSHI);
    assign load_val.ns   = {wdata[HI_W-1:0], stage_lo};
    assign load_val.frac = stage_frac;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            stage_lo   <= '0;
            stage_frac <= '0;
        end else if (wr) begin
            if (addr == A_NSLO)  stage_lo   <= wdata;
            if (addr == A_SUBNS) stage_frac <= wdata;
        end
    end
endmodule

// File: rtl/ptp_tod_snap.sv
module ptp_tod_snap
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  tod_t              live,
    input  logic [WORD_W-1:0] adj_word,
    input  logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] rdata
);
    tod_t snap;
    logic held;
    tod_t view;

    assign view = held ? snap : live;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap  <= '0;
            held  <= 1'b0;
            rdata <= '0;
        end else if (rd) begin
            case (addr)
                A_SUBNS: begin
                    snap  <= live;
                    held  <= 1'b1;
                    rdata <= live.frac;
                end
                A_NSLO:  rdata <= view.ns[WORD_W-1:0];
                A_NSHI: begin
                    rdata <= {{(WORD_W-HI_W){1'b0}}, view.ns[NS_W-1:WORD_W]};
                    held  <= 1'b0;
                end
                A_ADJ:   rdata <= adj_word;
                A_CTRL:  rdata <= ctrl_word;
                default: rdata <= '0;
            endcase
        end
    end

    assert_hi_pad_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_NSHI) |=> rdata[WORD_W-1:HI_W] == '0);

    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (held && !(rd && addr == A_SUBNS)) |=> snap == $past(snap));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [NS_W-1:0]   time_ns,
    output logic [FRAC_W-1:0] time_frac
);
    tod_t tod;
    tod_t tod_nxt;
    tod_t load_val;
    adj_t adj;
    logic off;
    logic load;

    ptp_tod_step u_step (
        .cur (tod),
        .adj (adj),
        .nxt (tod_nxt)
    );

    ptp_tod_wstage u_wstage (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .load     (load),
        .load_val (load_val)
    );

    ptp_tod_snap u_snap (
        .clk       (clk),
        .rst       (rst),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .live      (tod),
        .adj_word  (adj),
        .ctrl_word ({off, {(WORD_W-1){1'b0}}}),
        .rdata     (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tod <= '0;
            adj <= '0;
            off <= 1'b1;
        end else begin
            if (load)      tod <= load_val;
            else if (!off) tod <= tod_nxt;
            if (reg_wr && reg_addr == A_ADJ)  adj <= reg_wdata;
            if (reg_wr && reg_addr == A_CTRL) off <= reg_wdata[WORD_W-1];
        end
    end

    assign time_ns   = tod.ns;
    assign time_frac = tod.frac;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (tod == '0 && adj == '0 && off));

    assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (off && !load) |=> tod == $past(tod));

    assert_plain_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!off && !load && adj.mag == '0) |=>
        (tod.ns - $past(tod.ns) == NS_W'(STEP_NS) && tod.frac == $past(tod.frac)));

    assert_pos_trim_R4: assert property (@(posedge clk) disable iff (rst)
        (!off && !load && !adj.neg) |=>
        (tod.ns - $past(tod.ns) == NS_W'(STEP_NS) ||
         tod.ns - $past(tod.ns) == NS_W'(STEP_NS + 1)));

    assert_neg_trim_R4: assert property (@(posedge clk) disable iff (rst)
        (!off && !load && adj.neg) |=>
        (tod.ns - $past(tod.ns) == NS_W'(STEP_NS) ||
         tod.ns - $past(tod.ns) == NS_W'(STEP_NS - 1)));

    assert_load_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> tod == $past(load_val));
endmodule

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;
    import ptp_tod_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [WORD_W-1:0] reg_wdata = '0;
    logic [WORD_W-1:0] reg_rdata;
    logic [NS_W-1:0]   time_ns;
    logic [FRAC_W-1:0] time_frac;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ptp_tod_counter u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .time_ns   (time_ns),
        .time_frac (time_frac)
    );

    // arithmetic reference of the register-level behaviour
    logic [NS_W-1:0]         m_ns;
    logic [FRAC_W-1:0]       m_frac;
    logic [WORD_W-1:0]       m_adj;
    logic                    m_off;
    logic [WORD_W-1:0]       m_stlo;
    logic [FRAC_W-1:0]       m_stfr;
    logic [NS_W+FRAC_W-1:0]  m_snap;
    logic                    m_held;
    logic [WORD_W-1:0]       m_rdata;

    always @(posedge clk) begin
        logic [NS_W+FRAC_W-1:0] v;
        logic [NS_W-1:0]        seen;
        if (rst) begin
            m_ns = '0; m_frac = '0; m_adj = '0; m_off = 1'b1;
            m_stlo = '0; m_stfr = '0; m_snap = '0; m_held = 1'b0; m_rdata = '0;
        end else begin
            if (reg_rd) begin
                seen = m_held ? m_snap[NS_W+FRAC_W-1:FRAC_W] : m_ns;
                case (reg_addr)
                    3'd0: begin m_snap = {m_ns, m_frac}; m_held = 1'b1; m_rdata = m_frac; end
                    3'd1: m_rdata = seen[31:0];
                    3'd2: begin m_rdata = {24'd0, seen[39:32]}; m_held = 1'b0; end
                    3'd3: m_rdata = m_adj;
                    3'd4: m_rdata = {m_off, 31'd0};
                    default: m_rdata = '0;
                endcase
            end
            if (reg_wr && reg_addr == 3'd2) begin
                m_ns = {reg_wdata[7:0], m_stlo}; m_frac = m_stfr;
                m_stlo = '0; m_stfr = '0;
            end else if (!m_off) begin
                v = {m_ns, m_frac} + (72'd8 << 32);
                if (m_adj[31]) v = v - {41'd0, m_adj[30:0]};
                else           v = v + {41'd0, m_adj[30:0]};
                {m_ns, m_frac} = v;
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_stfr = reg_wdata;
                    3'd1: m_stlo = reg_wdata;
                    3'd3: m_adj  = reg_wdata;
                    3'd4: m_off  = reg_wdata[31];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [NS_W-1:0] act, input logic [NS_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(tag, {8'd0, reg_rdata}, {8'd0, m_rdata});
    endtask

    task automatic watch(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({tag, " ns"}, time_ns, m_ns);
            check({tag, " frac"}, {8'd0, time_frac}, {8'd0, m_frac});
        end
    endtask

    logic [31:0] adj_set [6] = '{32'h0000_0000, 32'h0000_1234, 32'h7FFF_FFFF,
                                 32'h8000_4321, 32'hFFFF_FFFF, 32'h8000_0000};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 ns", time_ns, '0);
        check("R1 frac", {8'd0, time_frac}, '0);
        rd_reg(3'd4, "R1 ctrl");
        check("R1 ctrl literal", {8'd0, reg_rdata}, {8'd0, 32'h8000_0000});
        rd_reg(3'd3, "R1 adj");
        // R2: halted holds, only bit 31 stored
        watch(6, "R2 halted");
        wr_reg(3'd4, 32'hFFFF_FFFF);
        rd_reg(3'd4, "R2 ctrl bits");
        check("R2 ctrl literal", {8'd0, reg_rdata}, {8'd0, 32'h8000_0000});
        // R9: staged load while halted
        wr_reg(3'd0, 32'h4000_0000);
        wr_reg(3'd1, 32'h1234_5678);
        wr_reg(3'd2, 32'hFFFF_FFAB);
        check("R9 load ns", time_ns, 40'hAB_1234_5678);
        check("R9 load frac", {8'd0, time_frac}, {8'd0, 32'h4000_0000});
        watch(4, "R2 held after load");
        // R3: run with zero adjust
        wr_reg(3'd4, 32'h0);
        watch(20, "R3 nominal");
        // R4/R10: sweep adjust words
        foreach (adj_set[k]) begin
            wr_reg(3'd3, adj_set[k]);
            rd_reg(3'd3, "R10 adj readback");
            check("R10 adj literal", {8'd0, reg_rdata}, {8'd0, adj_set[k]});
            watch(40, "R4 trim");
        end
        // R9: load without staged residue gives zero residue
        wr_reg(3'd3, 32'h0);
        wr_reg(3'd1, 32'h0000_1000);
        wr_reg(3'd2, 32'h0000_0001);
        watch(3, "R9 unstaged residue");
        // R5: wrap at 2^40
        wr_reg(3'd3, 32'h7FFF_FFFF);
        wr_reg(3'd1, 32'hFFFF_FFEC);
        wr_reg(3'd2, 32'h0000_00FF);
        watch(10, "R5 wrap");
        // R7: capture then delayed reads
        rd_reg(3'd0, "R7 capture");
        repeat (5) @(negedge clk);
        rd_reg(3'd1, "R7 held low");
        repeat (3) @(negedge clk);
        rd_reg(3'd2, "R7 held high");
        check("R6 high pad", {8'd0, reg_rdata[31:8]}, '0);
        // R8: no capture held
        rd_reg(3'd1, "R8 live low");
        rd_reg(3'd2, "R8 live high");
        // R7: re-capture
        rd_reg(3'd0, "R7 first capture");
        repeat (4) @(negedge clk);
        rd_reg(3'd0, "R7 re-capture");
        repeat (4) @(negedge clk);
        rd_reg(3'd1, "R7 re-captured low");
        rd_reg(3'd2, "R7 re-captured high");
        // R6: unmapped address
        rd_reg(3'd6, "R6 unmapped");
        check("R6 unmapped literal", {8'd0, reg_rdata}, '0);
        // R2: halt while running
        wr_reg(3'd4, 32'h8000_0000);
        watch(8, "R2 halt mid-run");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule